// File: doc/BRIEF.md
# Write-Through Set-Associative Cache Controller

This block sits between a requester that works on narrow words and a memory whose words are several requester words wide. Each cache line holds exactly one memory word, so filling a line takes one memory read. The low bits of the requester address pick a word lane inside the line. The next bits pick the set, and the remaining upper bits form the tag. Read hits are served from the cache with no memory traffic. A read miss issues one memory read, installs the returned word in a victim way chosen by least-recently-used order, and returns the selected lane.

Writes always go through to memory as a single masked word write. The requester data sits in its own lane, and the byte mask is zero in every other lane. A write that hits also merges its enabled bytes into the cached line. A write that misses leaves the cache untouched. Only one request is in flight at a time, so requests complete in arrival order. The requester holds a request until the block acknowledges it. Read data follows one cycle after the acknowledge.

Top module: `wt_cache`

## Requirements
- R1: While reset is asserted and directly after it, req_ack_o, rsp_valid_o and mem_req_o are low, and every line is invalid, so the first read of any address needs a memory read.
- R2: A read that hits is acknowledged in the cycle it is first presented (zero wait cycles) and issues no memory request.
- R3: A read that misses issues exactly one memory read with mem_addr_o equal to req_addr_i without its lane bits. It is acknowledged in the cycle mem_rvalid_i returns the word. A later read of any lane of that line hits.
- R4: rsp_valid_o is high exactly one cycle after each read acknowledge. rsp_rdata_o then holds lane k of the line, which is bits k*CPU_DW and upward, where k is the low log2(MEM_DW/CPU_DW) address bits.
- R5: Every write issues one memory write to the line address. The requester data sits in lane k of mem_wdata_o, and the other lanes are zero. mem_wmask_o carries req_wmask_i in byte lanes k*CPU_DW/8 and upward, and is zero elsewhere. The write is acknowledged in the cycle mem_ready_i accepts it.
- R6: A write that hits merges only its enabled bytes into the cached line. A following read of that word hits and returns the merged value.
- R7: A write that misses does not allocate a line. A following read of the same address misses, and it returns the value written to memory.
- R8: With all ways of a set valid, a miss replaces the least recently used way. Read hits and write hits both count as a use.
- R9: A write acknowledge never produces rsp_valid_o.
- R10: req_ack_o is only ever high while req_valid_i is high, and each acknowledge completes exactly one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present, held until acknowledged |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | CPU_AW | Requester word address (lane, set, tag from low to high) |
| req_wdata_i | input | CPU_DW | Write data |
| req_wmask_i | input | CPU_DW/8 | Byte enables for the write |
| req_ack_o | output | 1 | Request completed this cycle |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read acknowledge |
| rsp_rdata_o | output | CPU_DW | Read data |
| mem_req_o | output | 1 | Memory request |
| mem_write_o | output | 1 | Memory request is a write |
| mem_addr_o | output | MEM_AW | Memory word address |
| mem_wdata_o | output | MEM_DW | Memory write data |
| mem_wmask_o | output | MEM_DW/8 | Memory byte enables |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_rvalid_i | input | 1 | Memory read data returned |
| mem_rdata_i | input | MEM_DW | Memory read data |

## Verification
The properties assume that the requester keeps req_valid_i and every request field stable from the first cycle a request is presented until req_ack_o. They also assume that the memory answers each accepted read with exactly one mem_rvalid_i pulse and raises none otherwise. The bench drives each request from a task that holds all fields until it sees the acknowledge and then drops req_valid_i for at least one cycle. Its memory model returns each accepted read once, a fixed two cycles later, and accepts writes whenever the bench lets it.

// File: rtl/wt_cache_pkg.sv
`timescale 1ns/1ps
package wt_cache_pkg;
  typedef enum logic [1:0] {
    CTL_IDLE  = 2'd0,
    CTL_FETCH = 2'd1,
    CTL_FILL  = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/wt_cache_tags.sv
`timescale 1ns/1ps
module wt_cache_tags #(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int TAG_W = 6,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic [WAYS-1:0]  hit_o,
  output logic [WAYS-1:0]  valid_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [WAY_W-1:0] wr_way_i,
  input  logic [TAG_W-1:0] wr_tag_i
);
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (wr_en_i) begin
      vld_q[wr_idx_i][wr_way_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_q[wr_idx_i][wr_way_i] <= wr_tag_i;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign valid_o[w] = vld_q[lk_idx_i][w];
    assign hit_o[w]   = vld_q[lk_idx_i][w] && (tag_q[lk_idx_i][w] == lk_tag_i);
  end
endmodule

// File: rtl/wt_cache_lru.sv
`timescale 1ns/1ps
module wt_cache_lru #(
  parameter int SETS = 4,
  parameter int WAYS = 2,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [WAYS-1:0]  valid_i,
  input  logic             touch_i,
  input  logic [WAY_W-1:0] touch_way_i,
  output logic [WAY_W-1:0] victim_o
);
  // per-set ages form a permutation of 0..WAYS-1; 0 = most recent
  logic [WAY_W-1:0] age_q [SETS][WAYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i)
          age_q[idx_i][w] <= '0;
        else if (age_q[idx_i][w] < age_q[idx_i][touch_way_i])
          age_q[idx_i][w] <= age_q[idx_i][w] + 1'b1;
      end
    end
  end

  // lowest invalid way first, else the oldest way
  always_comb begin
    victim_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[idx_i][w] == WAY_W'(WAYS - 1)) victim_o = WAY_W'(w);
    for (int w = WAYS - 1; w >= 0; w--)
      if (!valid_i[w]) victim_o = WAY_W'(w);
  end
endmodule

// File: rtl/wt_cache_data.sv
`timescale 1ns/1ps
module wt_cache_data #(
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int MEM_DW = 128,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int MEM_BE = MEM_DW / 8
) (
  input  logic                        clk_i,
  input  logic [IDX_W-1:0]            rd_idx_i,
  output logic [WAYS-1:0][MEM_DW-1:0] rd_lines_o,
  input  logic                        wr_en_i,
  input  logic [IDX_W-1:0]            wr_idx_i,
  input  logic [WAY_W-1:0]            wr_way_i,
  input  logic [MEM_DW-1:0]           wr_data_i,
  input  logic [MEM_BE-1:0]           wr_be_i
);
  logic [MEM_DW-1:0] line_q [SETS][WAYS];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int b = 0; b < MEM_BE; b++)
        if (wr_be_i[b]) line_q[wr_idx_i][wr_way_i][b*8 +: 8] <= wr_data_i[b*8 +: 8];
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_lines_o[w] = line_q[rd_idx_i][w];
  end
endmodule

// File: rtl/wt_cache.sv
`timescale 1ns/1ps
module wt_cache
  import wt_cache_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int WAYS   = 2,
  parameter int CPU_DW = 32,
  parameter int MEM_AW = 8,
  parameter int MEM_DW = 128,
  localparam int SETS   = LINES / WAYS,
  localparam int SUB_N  = MEM_DW / CPU_DW,
  localparam int SUB_W  = $clog2(SUB_N),
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = MEM_AW - IDX_W,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int CPU_AW = SUB_W + MEM_AW,
  localparam int CPU_BE = CPU_DW / 8,
  localparam int MEM_BE = MEM_DW / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [CPU_AW-1:0] req_addr_i,
  input  logic [CPU_DW-1:0] req_wdata_i,
  input  logic [CPU_BE-1:0] req_wmask_i,
  output logic              req_ack_o,
  output logic              rsp_valid_o,
  output logic [CPU_DW-1:0] rsp_rdata_o,
  output logic              mem_req_o,
  output logic              mem_write_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [MEM_DW-1:0] mem_wdata_o,
  output logic [MEM_BE-1:0] mem_wmask_o,
  input  logic              mem_ready_i,
  input  logic              mem_rvalid_i,
  input  logic [MEM_DW-1:0] mem_rdata_i
);
  ctl_state_e state_q, state_d;

  logic [SUB_W-1:0] sub;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  assign sub = req_addr_i[SUB_W-1:0];
  assign idx = req_addr_i[SUB_W +: IDX_W];
  assign tag = req_addr_i[CPU_AW-1 -: TAG_W];

  logic [WAYS-1:0]             hit_vec, valid_vec;
  logic [WAYS-1:0][MEM_DW-1:0] set_lines;
  logic [WAY_W-1:0]            hit_way, victim_way;
  logic                        hit;

  logic                        tag_wr, data_wr, touch;
  logic [WAY_W-1:0]            data_way, touch_way;
  logic [MEM_DW-1:0]           data_wdata;
  logic [MEM_BE-1:0]           data_be;

  wt_cache_tags #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lk_idx_i (idx),
    .lk_tag_i (tag),
    .hit_o    (hit_vec),
    .valid_o  (valid_vec),
    .wr_en_i  (tag_wr),
    .wr_idx_i (idx),
    .wr_way_i (victim_way),
    .wr_tag_i (tag)
  );

  wt_cache_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idx_i       (idx),
    .valid_i     (valid_vec),
    .touch_i     (touch),
    .touch_way_i (touch_way),
    .victim_o    (victim_way)
  );

  wt_cache_data #(.SETS(SETS), .WAYS(WAYS), .MEM_DW(MEM_DW)) u_data (
    .clk_i      (clk_i),
    .rd_idx_i   (idx),
    .rd_lines_o (set_lines),
    .wr_en_i    (data_wr),
    .wr_idx_i   (idx),
    .wr_way_i   (data_way),
    .wr_data_i  (data_wdata),
    .wr_be_i    (data_be)
  );

  assign hit = |hit_vec;
  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  // lane views of the wide words
  logic [SUB_N-1:0][CPU_DW-1:0] hit_words, fill_words, wr_lanes;
  logic [SUB_N-1:0][CPU_BE-1:0] be_lanes;
  assign hit_words  = set_lines[hit_way];
  assign fill_words = mem_rdata_i;

  for (genvar k = 0; k < SUB_N; k++) begin : g_lane
    assign wr_lanes[k] = (sub == SUB_W'(k)) ? req_wdata_i : '0;
    assign be_lanes[k] = (sub == SUB_W'(k)) ? req_wmask_i : '0;
  end

  logic in_fill;
  assign in_fill = (state_q == CTL_FILL);

  always_comb begin
    state_d     = state_q;
    req_ack_o   = 1'b0;
    mem_req_o   = 1'b0;
    mem_write_o = 1'b0;
    tag_wr      = 1'b0;
    data_wr     = 1'b0;
    touch       = 1'b0;
    touch_way   = hit_way;
    data_way    = hit_way;
    data_wdata  = wr_lanes;
    data_be     = be_lanes;
    unique case (state_q)
      CTL_IDLE: begin
        if (req_valid_i) begin
          if (req_write_i) begin
            mem_req_o   = 1'b1;
            mem_write_o = 1'b1;
            if (mem_ready_i) begin
              req_ack_o = 1'b1;
              data_wr   = hit;
              touch     = hit;
            end
          end else if (hit) begin
            req_ack_o = 1'b1;
            touch     = 1'b1;
          end else begin
            state_d = CTL_FETCH;
          end
        end
      end
      CTL_FETCH: begin
        mem_req_o = 1'b1;
        if (mem_ready_i) state_d = CTL_FILL;
      end
      CTL_FILL: begin
        if (mem_rvalid_i) begin
          req_ack_o  = 1'b1;
          tag_wr     = 1'b1;
          data_wr    = 1'b1;
          data_way   = victim_way;
          data_wdata = mem_rdata_i;
          data_be    = '1;
          touch      = 1'b1;
          touch_way  = victim_way;
          state_d    = CTL_IDLE;
        end
      end
      default: state_d = CTL_IDLE;
    endcase
  end

  assign mem_addr_o  = req_addr_i[CPU_AW-1:SUB_W];
  assign mem_wdata_o = wr_lanes;
  assign mem_wmask_o = mem_write_o ? be_lanes : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= CTL_IDLE;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_o <= req_ack_o && !req_write_i;
      if (req_ack_o && !req_write_i)
        rsp_rdata_o <= in_fill ? fill_words[sub] : hit_words[sub];
    end
  end
endmodule

// File: rtl/wt_cache_chk.sv
`timescale 1ns/1ps
module wt_cache_chk #(
  parameter int CPU_AW = 10,
  parameter int SUB_W  = 2,
  parameter int MEM_AW = 8,
  parameter int CPU_BE = 4,
  parameter int MEM_BE = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [CPU_AW-1:0] req_addr_i,
  input logic              req_ack_o,
  input logic              rsp_valid_o,
  input logic              mem_req_o,
  input logic              mem_write_o,
  input logic [MEM_AW-1:0] mem_addr_o,
  input logic [MEM_BE-1:0] mem_wmask_o,
  input logic              mem_ready_i
);
  logic [MEM_BE-1:0] lane_sel;
  assign lane_sel = MEM_BE'({CPU_BE{1'b1}}) << (req_addr_i[SUB_W-1:0] * CPU_BE);

  // R10
  a_r10_ack_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ack_o |-> req_valid_i);

  // R4
  a_r4_rsp_after_read_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ack_o && !req_write_i) |=> rsp_valid_o);

  // R4, R9
  a_r4_rsp_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(req_ack_o && !req_write_i));

  // R9
  a_r9_write_no_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ack_o && req_write_i) |=> !rsp_valid_o);

  // R5
  a_r5_mask_in_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_write_o) |-> ((mem_wmask_o & ~lane_sel) == '0));

  // R5
  a_r5_write_ack_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ack_o && req_write_i) |-> (mem_req_o && mem_write_o && mem_ready_i));

  // R3
  a_r3_read_line_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_write_o) |-> (mem_addr_o == req_addr_i[CPU_AW-1:SUB_W]));
endmodule

bind wt_cache wt_cache_chk #(
  .CPU_AW (CPU_AW),
  .SUB_W  (SUB_W),
  .MEM_AW (MEM_AW),
  .CPU_BE (CPU_BE),
  .MEM_BE (MEM_BE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .req_ack_o   (req_ack_o),
  .rsp_valid_o (rsp_valid_o),
  .mem_req_o   (mem_req_o),
  .mem_write_o (mem_write_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wmask_o (mem_wmask_o),
  .mem_ready_i (mem_ready_i)
);

// File: tb/tb_wt_cache.sv
`timescale 1ns/1ps
module tb_wt_cache;
  localparam int CPU_DW = 32;
  localparam int MEM_DW = 128;
  localparam int MEM_AW = 8;
  localparam int CPU_AW = 10;
  localparam int CPU_BE = 4;
  localparam int MEM_BE = 16;
  localparam int MWORDS = 1 << MEM_AW;
  localparam int CWORDS = 1 << CPU_AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              req_valid = 1'b0, req_write = 1'b0;
  logic [CPU_AW-1:0] req_addr = '0;
  logic [CPU_DW-1:0] req_wdata = '0;
  logic [CPU_BE-1:0] req_wmask = '0;
  logic              req_ack, rsp_valid;
  logic [CPU_DW-1:0] rsp_rdata;
  logic              mem_req, mem_write, mem_rvalid;
  logic [MEM_AW-1:0] mem_addr;
  logic [MEM_DW-1:0] mem_wdata, mem_rdata;
  logic [MEM_BE-1:0] mem_wmask;
  logic              mem_rdy = 1'b1;

  wt_cache dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_wmask_i(req_wmask),
    .req_ack_o(req_ack), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mem_req_o(mem_req), .mem_write_o(mem_write), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_wmask_o(mem_wmask),
    .mem_ready_i(mem_rdy), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [CPU_DW-1:0] seed_word(int a);
    return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  // memory model: reads return two cycles after acceptance
  logic [MEM_DW-1:0] mem_q [MWORDS];
  logic              p1, p2;
  logic [MEM_AW-1:0] p1_a, p2_a;
  int                rd_cnt, wr_cnt;
  logic [MEM_AW-1:0] last_wa;
  logic [MEM_DW-1:0] last_wd;
  logic [MEM_BE-1:0] last_wm;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < MWORDS; a++)
        for (int k = 0; k < 4; k++) mem_q[a][k*32 +: 32] <= seed_word(a*4 + k);
      p1 <= 1'b0; p2 <= 1'b0; p1_a <= '0; p2_a <= '0;
      rd_cnt <= 0; wr_cnt <= 0;
      last_wa <= '0; last_wd <= '0; last_wm <= '0;
    end else begin
      p1   <= mem_req && !mem_write && mem_rdy;
      p1_a <= mem_addr;
      p2   <= p1;
      p2_a <= p1_a;
      if (mem_req && !mem_write && mem_rdy) rd_cnt <= rd_cnt + 1;
      if (mem_req && mem_write && mem_rdy) begin
        for (int b = 0; b < MEM_BE; b++)
          if (mem_wmask[b]) mem_q[mem_addr][b*8 +: 8] <= mem_wdata[b*8 +: 8];
        wr_cnt  <= wr_cnt + 1;
        last_wa <= mem_addr;
        last_wd <= mem_wdata;
        last_wm <= mem_wmask;
      end
    end
  end
  assign mem_rvalid = p2;
  assign mem_rdata  = mem_q[p2_a];

  // flat reference of requester words
  logic [CPU_DW-1:0] ref_w [CWORDS];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [CPU_DW-1:0] merge(logic [CPU_DW-1:0] o, logic [CPU_DW-1:0] d, logic [CPU_BE-1:0] m);
    logic [CPU_DW-1:0] r = o;
    for (int b = 0; b < CPU_BE; b++) if (m[b]) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  int lat;
  logic [CPU_DW-1:0] rd;
  logic rv;

  task automatic do_op(input logic wr, input logic [CPU_AW-1:0] a,
                       input logic [CPU_DW-1:0] d, input logic [CPU_BE-1:0] m);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_wmask = m;
    lat = 0;
    #1;
    while (!req_ack && lat < 100) begin
      @(negedge clk); #1; lat++;
    end
    @(negedge clk);
    rv = rsp_valid; rd = rsp_rdata;
    req_valid = 1'b0;
    if (wr) ref_w[a] = merge(ref_w[a], d, m);
  endtask

  task automatic t_reset();
    #1;
    chk(!req_ack && !rsp_valid && !mem_req, "R1 outputs idle in reset", {req_ack, rsp_valid, mem_req}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!req_ack && !rsp_valid && !mem_req, "R1/R10 idle after reset", {req_ack, rsp_valid, mem_req}, 0);
  endtask

  task automatic t_miss_hit();
    int r0 = rd_cnt;
    do_op(1'b0, 10'h013, '0, '0);
    chk(rd_cnt == r0 + 1, "R1/R3 cold read fetches once", rd_cnt - r0, 1);
    chk(lat == 3, "R3 miss ack on rvalid", lat, 3);
    chk(rv && rd == ref_w[10'h013], "R4 miss data lane 3", rd, ref_w[10'h013]);
    for (int k = 0; k < 4; k++) begin
      r0 = rd_cnt;
      do_op(1'b0, 10'h010 + 10'(k), '0, '0);
      chk(lat == 0 && rd_cnt == r0, "R2/R3 lane hit no fetch", lat, 0);
      chk(rv && rd == ref_w[10'h010 + k], "R4 hit data lane", rd, ref_w[10'h010 + k]);
    end
  endtask

  task automatic t_write_hit();
    int r0 = rd_cnt;
    int w0 = wr_cnt;
    do_op(1'b1, 10'h012, 32'h1122_3344, 4'b0101);
    chk(wr_cnt == w0 + 1 && lat == 0, "R5 one write acked on accept", lat, 0);
    chk(last_wa == 8'h04, "R5 write line addr", last_wa, 8'h04);
    chk(last_wm == 16'h0500, "R5 mask in lane 2 only", last_wm, 16'h0500);
    chk(last_wd == (128'h1122_3344 << 64), "R5 data in lane 2 only", last_wd, 128'h1122_3344 << 64);
    chk(!rv, "R9 no response for write", rv, 0);
    do_op(1'b0, 10'h012, '0, '0);
    chk(lat == 0 && rd_cnt == r0, "R6 read after write hit still hits", lat, 0);
    chk(rv && rd == ref_w[10'h012], "R6 merged bytes", rd, ref_w[10'h012]);
  endtask

  task automatic t_write_miss();
    int r0 = rd_cnt;
    do_op(1'b1, 10'h201, 32'hCAFE_F00D, 4'b1111);
    chk(last_wm == 16'h00F0 && last_wa == 8'h80, "R5 write miss lane 1", last_wm, 16'h00F0);
    chk(!rv, "R9 no response for write miss", rv, 0);
    do_op(1'b0, 10'h201, '0, '0);
    chk(rd_cnt == r0 + 1, "R7 no allocate on write miss", rd_cnt - r0, 1);
    chk(rv && rd == 32'hCAFE_F00D, "R7 read returns written value", rd, 32'hCAFE_F00D);
  endtask

  task automatic t_stall_write();
    mem_rdy = 1'b0;
    fork
      begin @(negedge clk); repeat (3) @(negedge clk); mem_rdy = 1'b1; end
    join_none
    do_op(1'b1, 10'h011, 32'hA0B0_C0D0, 4'b1000);
    chk(lat == 3, "R5 write waits for mem ready", lat, 3);
    do_op(1'b0, 10'h011, '0, '0);
    chk(rv && rd == ref_w[10'h011], "R6 merged after stalled write", rd, ref_w[10'h011]);
  endtask

  task automatic t_lru();
    int r0;
    do_op(1'b0, 10'h014, '0, '0);
    do_op(1'b0, 10'h024, '0, '0);
    do_op(1'b1, 10'h015, 32'h0F0F_0F0F, 4'b0011);
    r0 = rd_cnt;
    do_op(1'b0, 10'h034, '0, '0);
    chk(rd_cnt == r0 + 1, "R8 third tag misses", rd_cnt - r0, 1);
    r0 = rd_cnt;
    do_op(1'b0, 10'h016, '0, '0);
    chk(rd_cnt == r0 && lat == 0, "R8 write-touched way kept", rd_cnt - r0, 0);
    chk(rv && rd == ref_w[10'h016], "R8 kept line data", rd, ref_w[10'h016]);
    r0 = rd_cnt;
    do_op(1'b0, 10'h024, '0, '0);
    chk(rd_cnt == r0 + 1, "R8 LRU way evicted", rd_cnt - r0, 1);
  endtask

  task automatic t_random();
    int errs = 0;
    for (int i = 0; i < 400; i++) begin
      logic wr = ($urandom % 3) == 0;
      logic [CPU_AW-1:0] a = CPU_AW'($urandom % 64);
      logic [CPU_DW-1:0] d = $urandom;
      logic [CPU_BE-1:0] m = CPU_BE'($urandom);
      logic [CPU_DW-1:0] e = ref_w[a];
      do_op(wr, a, d, m);
      if (wr) begin
        if (rv) begin errs++; chk(1'b0, "R9 random write response", rv, 0); end
      end else if (!rv || rd != e) begin
        errs++;
        chk(1'b0, "R4/R6 random read", rd, e);
      end
    end
    chk(errs == 0, "R4/R6/R7 random sequence", errs, 0);
  endtask

  initial begin
    for (int a = 0; a < CWORDS; a++) ref_w[a] = seed_word(a);
    repeat (3) @(negedge clk);
    t_reset();
    t_miss_hit();
    t_write_hit();
    t_write_miss();
    t_stall_write();
    t_lru();
    t_random();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule